// File: doc/BRIEF.md
# Conversion Result Window Monitor

This block sits beside an analog-to-digital converter and inspects every finished conversion. Each result arrives with its channel number and a tag that says whether it came from the regular sequence or the inserted sequence. When a checked result lies outside a window bounded by a low and a high threshold, the block raises a sticky event flag. It also drives an interrupt line, which is the flag gated by an interrupt enable.

Checking can cover every channel of the regular group, the inserted group, or both. Each group has its own enable. Checking can instead be narrowed to a single selected channel.

The configuration is changed with one-cycle commands:
- A single-channel command arms both group enables and the single-channel bit, and loads the channel select.
- A group command loads the two group enables.
- An off command clears all monitoring state.

The current monitoring configuration is visible on dedicated outputs.

Top module: `awd_window_mon`

## Requirements
- R1: After reset, evt_flag, irq, mon_reg_en, mon_ins_en and mon_single are 0 and mon_chan is 0. The low threshold resets to 0 and the high threshold resets to all ones, so no result can raise an event.
- R2: A checked result raises the event only when it is strictly greater than the high threshold. A result equal to the high threshold raises nothing.
- R3: A checked result raises the event only when it is strictly less than the low threshold. A result equal to the low threshold raises nothing.
- R4: A result with res_ins=0 (regular group) is checked only while mon_reg_en is 1. A result with res_ins=1 (inserted group) is checked only while mon_ins_en is 1.
- R5: mode_cmd=2'b01 (single) with cmd_chan below NUM_CH sets mon_reg_en, mon_ins_en and mon_single to 1 and loads mon_chan from cmd_chan. While mon_single is 1, a result whose channel differs from mon_chan is not checked.
- R6: mode_cmd=2'b10 (group) loads mon_reg_en from cmd_reg and mon_ins_en from cmd_ins. It clears mon_single and leaves mon_chan unchanged.
- R7: mode_cmd=2'b11 (off) clears mon_reg_en, mon_ins_en, mon_single and mon_chan.
- R8: evt_flag stays set until a flag_clr pulse clears it. If flag_clr and a new event occur in the same cycle, evt_flag stays set.
- R9: irq is 1 exactly when evt_flag is 1 and irq_en is 1.
- R10: With CMP_PIPE=0, the flag reflects a result at the first clock edge that samples res_valid, and not before that edge.
- R11: A single-channel command whose cmd_chan is NUM_CH or higher changes no configuration.
- R12: thr_we loads both thresholds at once. Results presented after that edge are compared against the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Conversion-done strobe |
| res_data | input | DATA_W | Conversion result |
| res_chan | input | CH_W | Channel of the result |
| res_ins | input | 1 | 1 = inserted group, 0 = regular group |
| thr_we | input | 1 | Load both thresholds |
| thr_lo_wr | input | THR_W | New low threshold |
| thr_hi_wr | input | THR_W | New high threshold |
| mode_cmd | input | 2 | 00 none, 01 single, 10 group, 11 off |
| cmd_chan | input | CH_W | Channel for the single command |
| cmd_reg | input | 1 | Regular enable for the group command |
| cmd_ins | input | 1 | Inserted enable for the group command |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clear the event flag |
| evt_flag | output | 1 | Sticky out-of-window flag |
| irq | output | 1 | Gated interrupt |
| mon_reg_en | output | 1 | Regular group checked |
| mon_ins_en | output | 1 | Inserted group checked |
| mon_single | output | 1 | Single-channel mode active |
| mon_chan | output | CH_W | Selected channel |

## Verification
The hardest case to reach is a clear that meets a new out-of-window result in the same cycle, because the two inputs come from unrelated sources. The stimulus sets the flag, then presents flag_clr together with a result above the high threshold on an enabled group.

A second hard case is the leftover channel select after a group command. The stimulus arms a single channel, switches to group mode, and checks that other channels are now monitored. It then uses the off command and shows the select returning to zero.

Threshold-equal values are driven on both bounds to pin down the strict comparisons.

// File: rtl/awd_pkg.sv
package awd_pkg;
   typedef enum logic [1:0] {
      AWD_CMD_NONE   = 2'b00,
      AWD_CMD_SINGLE = 2'b01,
      AWD_CMD_GROUP  = 2'b10,
      AWD_CMD_OFF    = 2'b11
   } awd_cmd_e;
endpackage

// File: rtl/awd_cfg.sv
module awd_cfg
   import awd_pkg::*;
#(
   parameter int THR_W  = 16,
   parameter int NUM_CH = 19,
   parameter int CH_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             thr_we,
   input  logic [THR_W-1:0] thr_lo_wr,
   input  logic [THR_W-1:0] thr_hi_wr,
   input  awd_cmd_e         cmd,
   input  logic [CH_W-1:0]  cmd_chan,
   input  logic             cmd_reg,
   input  logic             cmd_ins,
   output logic [THR_W-1:0] thr_lo,
   output logic [THR_W-1:0] thr_hi,
   output logic             reg_en,
   output logic             ins_en,
   output logic             single,
   output logic [CH_W-1:0]  chan
);
   localparam logic [CH_W:0] CH_LIMIT = (CH_W+1)'(NUM_CH);

   logic chan_ok;
   assign chan_ok = ({1'b0, cmd_chan} < CH_LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_lo <= '0;
         thr_hi <= '1;
      end else if (thr_we) begin
         thr_lo <= thr_lo_wr;
         thr_hi <= thr_hi_wr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_en <= 1'b0;
         ins_en <= 1'b0;
         single <= 1'b0;
         chan   <= '0;
      end else begin
         unique case (cmd)
            AWD_CMD_SINGLE: if (chan_ok) begin
               reg_en <= 1'b1;
               ins_en <= 1'b1;
               single <= 1'b1;
               chan   <= cmd_chan;
            end
            AWD_CMD_GROUP: begin
               reg_en <= cmd_reg;
               ins_en <= cmd_ins;
               single <= 1'b0;
            end
            AWD_CMD_OFF: begin
               reg_en <= 1'b0;
               ins_en <= 1'b0;
               single <= 1'b0;
               chan   <= '0;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/awd_cmp.sv
module awd_cmp #(
   parameter int DATA_W = 12,
   parameter int THR_W  = 16,
   parameter int CH_W   = 5
) (
   input  logic              res_valid,
   input  logic [DATA_W-1:0] res_data,
   input  logic [CH_W-1:0]   res_chan,
   input  logic              res_ins,
   input  logic [THR_W-1:0]  thr_lo,
   input  logic [THR_W-1:0]  thr_hi,
   input  logic              reg_en,
   input  logic              ins_en,
   input  logic              single,
   input  logic [CH_W-1:0]   chan,
   output logic              hit
);
   logic [THR_W-1:0] value;
   logic             grp_on;
   logic             chan_on;
   logic             outside;

   assign value   = THR_W'(res_data);
   assign grp_on  = res_ins ? ins_en : reg_en;
   assign chan_on = !single || (res_chan == chan);
   assign outside = (value > thr_hi) || (value < thr_lo);
   assign hit     = res_valid && grp_on && chan_on && outside;
endmodule

// File: rtl/awd_flag.sv
module awd_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic irq_en,
   output logic flag,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (set_i)
         flag <= 1'b1;
      else if (clr_i)
         flag <= 1'b0;
   end

   assign irq = flag & irq_en;
endmodule

// File: rtl/awd_window_mon.sv
module awd_window_mon
   import awd_pkg::*;
#(
   parameter int DATA_W   = 12,
   parameter int THR_W    = 16,
   parameter int NUM_CH   = 19,
   parameter int CMP_PIPE = 0,
   localparam int CH_W    = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_valid,
   input  logic [DATA_W-1:0] res_data,
   input  logic [CH_W-1:0]   res_chan,
   input  logic              res_ins,
   input  logic              thr_we,
   input  logic [THR_W-1:0]  thr_lo_wr,
   input  logic [THR_W-1:0]  thr_hi_wr,
   input  logic [1:0]        mode_cmd,
   input  logic [CH_W-1:0]   cmd_chan,
   input  logic              cmd_reg,
   input  logic              cmd_ins,
   input  logic              irq_en,
   input  logic              flag_clr,
   output logic              evt_flag,
   output logic              irq,
   output logic              mon_reg_en,
   output logic              mon_ins_en,
   output logic              mon_single,
   output logic [CH_W-1:0]   mon_chan
);
   if (DATA_W > THR_W) begin : g_bad_w
      $error("DATA_W must not exceed THR_W");
   end
   if (NUM_CH < 2) begin : g_bad_ch
      $error("NUM_CH must be at least 2");
   end
   if (CMP_PIPE != 0 && CMP_PIPE != 1) begin : g_bad_pipe
      $error("CMP_PIPE must be 0 or 1");
   end

   logic [THR_W-1:0] thr_lo, thr_hi;
   logic             hit;
   logic             flag_set;

   awd_cfg #(.THR_W(THR_W), .NUM_CH(NUM_CH), .CH_W(CH_W)) i_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .thr_we    (thr_we),
      .thr_lo_wr (thr_lo_wr),
      .thr_hi_wr (thr_hi_wr),
      .cmd       (awd_cmd_e'(mode_cmd)),
      .cmd_chan  (cmd_chan),
      .cmd_reg   (cmd_reg),
      .cmd_ins   (cmd_ins),
      .thr_lo    (thr_lo),
      .thr_hi    (thr_hi),
      .reg_en    (mon_reg_en),
      .ins_en    (mon_ins_en),
      .single    (mon_single),
      .chan      (mon_chan)
   );

   awd_cmp #(.DATA_W(DATA_W), .THR_W(THR_W), .CH_W(CH_W)) i_cmp (
      .res_valid (res_valid),
      .res_data  (res_data),
      .res_chan  (res_chan),
      .res_ins   (res_ins),
      .thr_lo    (thr_lo),
      .thr_hi    (thr_hi),
      .reg_en    (mon_reg_en),
      .ins_en    (mon_ins_en),
      .single    (mon_single),
      .chan      (mon_chan),
      .hit       (hit)
   );

   if (CMP_PIPE == 1) begin : g_pipe
      logic hit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hit_q <= 1'b0;
         else        hit_q <= hit;
      end
      assign flag_set = hit_q;
   end else begin : g_direct
      assign flag_set = hit;
   end

   awd_flag i_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (flag_set),
      .clr_i  (flag_clr),
      .irq_en (irq_en),
      .flag   (evt_flag),
      .irq    (irq)
   );
endmodule

// File: rtl/awd_window_mon_chk.sv
module awd_window_mon_chk #(
   parameter int NUM_CH = 19,
   parameter int CH_W   = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic [1:0]      mode_cmd,
   input logic [CH_W-1:0] cmd_chan,
   input logic            flag_clr,
   input logic            flag_set,
   input logic            irq_en,
   input logic            evt_flag,
   input logic            irq,
   input logic            mon_reg_en,
   input logic            mon_ins_en,
   input logic            mon_single,
   input logic [CH_W-1:0] mon_chan
);
   localparam logic [CH_W:0] CH_LIMIT = (CH_W+1)'(NUM_CH);

   logic chan_ok;
   assign chan_ok = ({1'b0, cmd_chan} < CH_LIMIT);

   a_r8_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_flag && !flag_clr) |=> evt_flag);

   a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      flag_set |=> evt_flag);

   a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !flag_set) |=> !evt_flag);

   a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (evt_flag && irq_en));

   a_r5_single_arms: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_cmd == 2'b01 && chan_ok) |=>
         (mon_single && mon_reg_en && mon_ins_en && mon_chan == $past(cmd_chan)));

   a_r11_bad_chan_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_cmd == 2'b01 && !chan_ok) |=>
         ($stable(mon_chan) && $stable(mon_single) && $stable(mon_reg_en) && $stable(mon_ins_en)));

   a_r6_single_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
      mon_single |-> (mon_reg_en && mon_ins_en));

   a_r7_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_cmd == 2'b11) |=>
         (!mon_reg_en && !mon_ins_en && !mon_single && mon_chan == '0));
endmodule

bind awd_window_mon awd_window_mon_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_chk (.*);

// File: tb/test_awd_window_mon.sv
module test_awd_window_mon;
   localparam int DATA_W = 12;
   localparam int THR_W  = 16;
   localparam int NUM_CH = 19;
   localparam int CH_W   = $clog2(NUM_CH);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              res_valid = 1'b0;
   logic [DATA_W-1:0] res_data = '0;
   logic [CH_W-1:0]   res_chan = '0;
   logic              res_ins = 1'b0;
   logic              thr_we = 1'b0;
   logic [THR_W-1:0]  thr_lo_wr = '0;
   logic [THR_W-1:0]  thr_hi_wr = '0;
   logic [1:0]        mode_cmd = 2'b00;
   logic [CH_W-1:0]   cmd_chan = '0;
   logic              cmd_reg = 1'b0;
   logic              cmd_ins = 1'b0;
   logic              irq_en = 1'b0;
   logic              flag_clr = 1'b0;
   logic              evt_flag, irq, mon_reg_en, mon_ins_en, mon_single;
   logic [CH_W-1:0]   mon_chan;

   always #2 clk = ~clk;

   awd_window_mon i_awd_window_mon (.*);

   typedef struct {
      string           tag;
      logic            flag;
      logic            irq;
      logic            reg_en;
      logic            ins_en;
      logic            single;
      logic [CH_W-1:0] chan;
   } exp_t;

   exp_t exp_q[$];
   int   n_run  = 0;
   int   n_fail = 0;

   // reference state, derived from the requirements
   logic             m_flag = 0, m_reg = 0, m_ins = 0, m_single = 0;
   logic [CH_W-1:0]  m_chan = '0;
   logic [THR_W-1:0] m_lo = '0, m_hi = '1;

   task automatic step(string tag);
      logic hit;
      logic grp;
      exp_t e;
      grp = res_ins ? m_ins : m_reg;
      hit = res_valid && grp && (!m_single || res_chan == m_chan) &&
            ((THR_W'(res_data) > m_hi) || (THR_W'(res_data) < m_lo));
      m_flag = hit | (m_flag & ~flag_clr);
      if (thr_we) begin m_lo = thr_lo_wr; m_hi = thr_hi_wr; end
      case (mode_cmd)
         2'b01: if (cmd_chan < NUM_CH) begin
            m_reg = 1; m_ins = 1; m_single = 1; m_chan = cmd_chan;
         end
         2'b10: begin m_reg = cmd_reg; m_ins = cmd_ins; m_single = 0; end
         2'b11: begin m_reg = 0; m_ins = 0; m_single = 0; m_chan = '0; end
         default: ;
      endcase
      e.tag = tag; e.flag = m_flag; e.irq = m_flag & irq_en;
      e.reg_en = m_reg; e.ins_en = m_ins; e.single = m_single; e.chan = m_chan;
      exp_q.push_back(e);
      @(negedge clk);
      res_valid = 0; thr_we = 0; mode_cmd = 2'b00; flag_clr = 0;
   endtask

   task automatic strobe(logic [DATA_W-1:0] d, logic [CH_W-1:0] c, logic ins, string tag);
      res_valid = 1; res_data = d; res_chan = c; res_ins = ins;
      step(tag);
   endtask

   // monitor: compares one expected item per cycle, away from the edge
   always begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_run++;
         if (evt_flag !== e.flag || irq !== e.irq || mon_reg_en !== e.reg_en ||
             mon_ins_en !== e.ins_en || mon_single !== e.single || mon_chan !== e.chan) begin
            n_fail++;
            $display("FAIL %s: got flag=%b irq=%b reg=%b ins=%b single=%b chan=%0d exp flag=%b irq=%b reg=%b ins=%b single=%b chan=%0d",
                     e.tag, evt_flag, irq, mon_reg_en, mon_ins_en, mon_single, mon_chan,
                     e.flag, e.irq, e.reg_en, e.ins_en, e.single, e.chan);
         end
      end
   end

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      n_run++;
      if (evt_flag !== 0 || irq !== 0 || mon_reg_en !== 0 || mon_ins_en !== 0 ||
          mon_single !== 0 || mon_chan !== 0) begin
         n_fail++;
         $display("FAIL R1: got flag=%b irq=%b reg=%b ins=%b single=%b chan=%0d exp all 0",
                  evt_flag, irq, mon_reg_en, mon_ins_en, mon_single, mon_chan);
      end
      irq_en = 1;
      strobe(12'hFFF, 5'd3, 0, "R1 default thresholds, disabled");
      irq_en = 0;
      // R12/R6: program window, regular only
      thr_we = 1; thr_lo_wr = 16'h0100; thr_hi_wr = 16'h0800;
      mode_cmd = 2'b10; cmd_reg = 1; cmd_ins = 0;
      step("R12 R6 group regular");
      strobe(12'h800, 5'd3, 0, "R2 equal high");
      strobe(12'h100, 5'd3, 0, "R3 equal low");
      strobe(12'h900, 5'd3, 1, "R4 inserted ignored");
      // R10: output not yet changed before the edge
      res_valid = 1; res_data = 12'h801; res_chan = 5'd3; res_ins = 0;
      #1;
      n_run++;
      if (evt_flag !== 0) begin
         n_fail++;
         $display("FAIL R10: got flag=%b exp 0 before edge", evt_flag);
      end
      step("R2 above high R10");
      irq_en = 1;
      step("R9 irq enabled");
      irq_en = 0;
      step("R9 irq masked");
      irq_en = 1;
      flag_clr = 1;
      step("R8 clear");
      strobe(12'h0FF, 5'd7, 0, "R3 below low");
      flag_clr = 1;
      strobe(12'hFFF, 5'd2, 0, "R8 clear with event");
      flag_clr = 1;
      step("R8 clear again");
      // R5 single channel
      mode_cmd = 2'b01; cmd_chan = 5'd5;
      step("R5 single arm");
      strobe(12'hFFF, 5'd4, 0, "R5 other channel");
      strobe(12'hFFF, 5'd5, 1, "R5 selected channel");
      flag_clr = 1;
      step("R8 clear");
      mode_cmd = 2'b01; cmd_chan = 5'd25;
      step("R11 out-of-range channel");
      mode_cmd = 2'b01; cmd_chan = 5'd19;
      step("R11 channel equal to limit");
      // R6 group inserted only, chan kept
      mode_cmd = 2'b10; cmd_reg = 0; cmd_ins = 1;
      step("R6 group inserted");
      strobe(12'h000, 5'd4, 1, "R6 any channel inserted");
      flag_clr = 1;
      strobe(12'h000, 5'd4, 0, "R4 regular disabled");
      // R12 new thresholds
      thr_we = 1; thr_lo_wr = 16'h0000; thr_hi_wr = 16'h07FF;
      step("R12 rewrite");
      strobe(12'h800, 5'd1, 1, "R12 new high");
      flag_clr = 1;
      step("R8 clear");
      // R7 off
      mode_cmd = 2'b11;
      step("R7 off");
      strobe(12'hFFF, 5'd0, 1, "R7 nothing checked");
      strobe(12'hFFF, 5'd0, 0, "R7 nothing checked regular");
      mode_cmd = 2'b10; cmd_reg = 1; cmd_ins = 1;
      step("R6 both groups");
      strobe(12'h801, 5'd9, 0, "R4 regular on");
      @(negedge clk);
      @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule